// File: doc/BRIEF.md
# Masked Interrupt Vector Controller

This block gathers sixteen level-sensitive interrupt lines into a source register that follows the line levels clock by clock. It combines that register with a mask that software can write, and the result is a pending set. A single interrupt output is high whenever any pending bit is set. A vector register reports the lowest-numbered pending line, so a handler can find the line to service with one read.

Software reaches the block through a small 16-bit register port with a write strobe and a read strobe. The vector sits at offset 0x0 and can only be read. The mask sits at offset 0x2 and can be read and written. The vector value is (index + 1) << 2, so a value of zero means that nothing is pending.

The interrupt output is driven by a two-state machine. The states are IRQ_QUIET and IRQ_RAISED. The transition QUIET_TO_RAISED is taken when the pending set is non-zero, and RAISED_TO_QUIET is taken when it becomes empty. Because the output comes from the state register, it lags a source or mask change by one clock.

Top module: `irq_vector_ctrl`

## Requirements
- R1: Every clock, each source bit takes the level of its input line: a high line sets the bit and a low line clears it.
- R2: The pending set is the bitwise AND of the source register and the mask. `irq_o` is high in the clock after the pending set is non-zero and low in the clock after it is empty (states IRQ_RAISED and IRQ_QUIET).
- R3: A read at offset 0x0 returns (i+1)<<2, where i is the lowest set bit of the pending set, and returns 0 when the pending set is empty.
- R4: A write at offset 0x2 replaces the whole mask with the write data. A later read at offset 0x2 returns the current mask.
- R5: While reset is active the mask is 0x0010, the source register is zero and `irq_o` is low.
- R6: Writes at any offset other than 0x2, including offset 0x0, leave the mask unchanged.
- R7: Reads at any offset other than 0x0 and 0x2 return 0.
- R8: Reading the vector changes neither the mask nor the pending state: back-to-back vector reads return the same value.
- R9: Read data appears on `bus_rdata_o` in the clock after `bus_rd_i` is sampled high, and it holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_lvl_i | input | 16 | Level-sensitive interrupt lines, bit i is line i |
| bus_addr_i | input | 4 | Byte offset of the register access |
| bus_wr_i | input | 1 | Write strobe |
| bus_wdata_i | input | 16 | Write data |
| bus_rd_i | input | 1 | Read strobe |
| bus_rdata_o | output | 16 | Registered read data |
| irq_o | output | 1 | Combined interrupt output, registered |

## Verification
The bound checker checks several rules on every clock. It checks that the output follows the pending set with exactly one clock of lag, in both directions. It checks that a mask write takes its data, and that any other access leaves the mask stable. It also checks that reads of an empty vector or of an unmapped offset return zero. The vector encoding for each priority position, level-following of the sources, and the reset value of the mask can only be shown by the bench. It does this through sweeps over every single line, every mask bit, suffix patterns and a long series of pseudo-random line and mask pairs, each compared against an arithmetic model.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
    typedef enum logic {
        IRQ_QUIET  = 1'b0,
        IRQ_RAISED = 1'b1
    } irq_state_e;

    localparam int unsigned VEC_SHIFT_DEF = 2;
endpackage

// File: rtl/ivc_src_latch.sv
module ivc_src_latch #(
    parameter int unsigned WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] lvl_i,
    output logic [WIDTH-1:0] src_o
);
    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                src_o[g] <= 1'b0;
            end else begin
                src_o[g] <= lvl_i[g];
            end
        end
    end
endmodule

// File: rtl/ivc_mask_reg.sv
module ivc_mask_reg #(
    parameter int unsigned   WIDTH    = 16,
    parameter int unsigned   ADDR_W   = 4,
    parameter logic [15:0]   MASK_RST = 16'h0010,
    parameter int unsigned   MASK_OFF = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [WIDTH-1:0]  wdata_i,
    output logic [WIDTH-1:0]  mask_o
);
    localparam logic [ADDR_W-1:0] OFF = ADDR_W'(MASK_OFF);
    localparam logic [WIDTH-1:0]  RST = WIDTH'(MASK_RST);

    logic hit;
    assign hit = wr_i && (addr_i == OFF);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_o <= RST;
        end else if (hit) begin
            mask_o <= wdata_i;
        end
    end
endmodule

// File: rtl/ivc_prio_enc.sv
module ivc_prio_enc #(
    parameter int unsigned WIDTH = 16,
    parameter int unsigned SHIFT = 2
) (
    input  logic [WIDTH-1:0] pend_i,
    output logic [WIDTH-1:0] vec_o,
    output logic             any_o
);
    logic [WIDTH:0]   below;
    logic [WIDTH-1:0] first;

    assign below[0] = 1'b0;
    for (genvar g = 0; g < WIDTH; g++) begin : g_chain
        assign first[g]   = pend_i[g] & ~below[g];
        assign below[g+1] = below[g] | pend_i[g];
    end

    assign any_o = below[WIDTH];

    always_comb begin
        vec_o = '0;
        for (int k = 0; k < int'(WIDTH); k++) begin
            if (first[k]) begin
                vec_o = vec_o | WIDTH'((k + 1) << SHIFT);
            end
        end
    end
endmodule

// File: rtl/ivc_irq_fsm.sv
module ivc_irq_fsm
    import ivc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic any_i,
    output logic irq_o
);
    irq_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_QUIET:  if (any_i)  state_d = IRQ_RAISED;
            IRQ_RAISED: if (!any_i) state_d = IRQ_QUIET;
            default:    state_d = IRQ_QUIET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= IRQ_QUIET;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case (state_q)
            IRQ_RAISED: irq_o = 1'b1;
            default:    irq_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl #(
    parameter int unsigned WIDTH    = 16,
    parameter int unsigned ADDR_W   = 4,
    parameter logic [15:0] MASK_RST = 16'h0010,
    parameter int unsigned VEC_OFF  = 0,
    parameter int unsigned MASK_OFF = 2,
    parameter int unsigned SHIFT    = ivc_pkg::VEC_SHIFT_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WIDTH-1:0]  irq_lvl_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic              bus_wr_i,
    input  logic [WIDTH-1:0]  bus_wdata_i,
    input  logic              bus_rd_i,
    output logic [WIDTH-1:0]  bus_rdata_o,
    output logic              irq_o
);
    localparam logic [ADDR_W-1:0] A_VEC  = ADDR_W'(VEC_OFF);
    localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(MASK_OFF);

    logic [WIDTH-1:0] src_q;
    logic [WIDTH-1:0] mask_q;
    logic [WIDTH-1:0] pend_w;
    logic [WIDTH-1:0] vec_w;
    logic             any_w;
    logic [WIDTH-1:0] rd_mux;

    ivc_src_latch #(.WIDTH(WIDTH)) u_src (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl_i (irq_lvl_i),
        .src_o (src_q)
    );

    ivc_mask_reg #(
        .WIDTH    (WIDTH),
        .ADDR_W   (ADDR_W),
        .MASK_RST (MASK_RST),
        .MASK_OFF (MASK_OFF)
    ) u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (bus_wr_i),
        .addr_i  (bus_addr_i),
        .wdata_i (bus_wdata_i),
        .mask_o  (mask_q)
    );

    assign pend_w = src_q & mask_q;

    ivc_prio_enc #(.WIDTH(WIDTH), .SHIFT(SHIFT)) u_enc (
        .pend_i (pend_w),
        .vec_o  (vec_w),
        .any_o  (any_w)
    );

    ivc_irq_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .any_i (any_w),
        .irq_o (irq_o)
    );

    always_comb begin
        if (bus_addr_i == A_VEC) begin
            rd_mux = vec_w;
        end else if (bus_addr_i == A_MASK) begin
            rd_mux = mask_q;
        end else begin
            rd_mux = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata_o <= '0;
        end else if (bus_rd_i) begin
            bus_rdata_o <= rd_mux;
        end
    end
endmodule

// File: rtl/ivc_checker.sv
module ivc_checker #(
    parameter int unsigned WIDTH    = 16,
    parameter int unsigned ADDR_W   = 4,
    parameter int unsigned VEC_OFF  = 0,
    parameter int unsigned MASK_OFF = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr_i,
    input logic              bus_wr_i,
    input logic [WIDTH-1:0]  bus_wdata_i,
    input logic              bus_rd_i,
    input logic [WIDTH-1:0]  bus_rdata_o,
    input logic              irq_o,
    input logic [WIDTH-1:0]  mask_q,
    input logic [WIDTH-1:0]  pend_w
);
    localparam logic [ADDR_W-1:0] A_VEC  = ADDR_W'(VEC_OFF);
    localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(MASK_OFF);

    p_irq_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_w != '0) |=> irq_o);

    p_irq_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_w == '0) |=> !irq_o);

    p_mask_take_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_i && bus_addr_i == A_MASK) |=> (mask_q == $past(bus_wdata_i)));

    p_mask_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr_i && bus_addr_i == A_MASK) |=> $stable(mask_q));

    p_vec_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_i && bus_addr_i == A_VEC && pend_w == '0) |=> (bus_rdata_o == '0));

    p_unmapped_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_i && bus_addr_i != A_VEC && bus_addr_i != A_MASK) |=> (bus_rdata_o == '0));

    p_rdata_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd_i |=> $stable(bus_rdata_o));
endmodule

bind irq_vector_ctrl ivc_checker #(
    .WIDTH    (WIDTH),
    .ADDR_W   (ADDR_W),
    .VEC_OFF  (VEC_OFF),
    .MASK_OFF (MASK_OFF)
) u_ivc_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr_i  (bus_addr_i),
    .bus_wr_i    (bus_wr_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_rd_i    (bus_rd_i),
    .bus_rdata_o (bus_rdata_o),
    .irq_o       (irq_o),
    .mask_q      (mask_q),
    .pend_w      (pend_w)
);

// File: tb/tb_irq_vector_ctrl.sv
module tb_irq_vector_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] irq_lvl_i = '0;
    logic [3:0]  bus_addr_i = '0;
    logic        bus_wr_i = 1'b0;
    logic [15:0] bus_wdata_i = '0;
    logic        bus_rd_i = 1'b0;
    logic [15:0] bus_rdata_o;
    logic        irq_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    irq_vector_ctrl dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .irq_lvl_i   (irq_lvl_i),
        .bus_addr_i  (bus_addr_i),
        .bus_wr_i    (bus_wr_i),
        .bus_wdata_i (bus_wdata_i),
        .bus_rd_i    (bus_rd_i),
        .bus_rdata_o (bus_rdata_o),
        .irq_o       (irq_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [15:0] exp_vec(input logic [15:0] p);
        for (int k = 0; k < 16; k++) begin
            if (p[k]) return 16'((k + 1) * 4);
        end
        return 16'h0;
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic set_lines(input logic [15:0] v);
        @(negedge clk);
        irq_lvl_i = v;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_rd_i = 1'b1;
        bus_addr_i = a;
        @(negedge clk);
        bus_rd_i = 1'b0;
        d = bus_rdata_o;
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_wr_i = 1'b1;
        bus_addr_i = a;
        bus_wdata_i = d;
        @(negedge clk);
        bus_wr_i = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog R1 actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [15:0] d, d2, lines, mask;
        logic [15:0] lf;

        repeat (3) @(negedge clk);
        // R5: state during reset
        chk("R5 irq in reset", {15'h0, irq_o}, 16'h0);
        rst_n = 1'b1;
        rd(4'h2, d);
        chk("R5 mask reset value", d, 16'h0010);
        rd(4'h0, d);
        chk("R5 vector after reset", d, 16'h0);

        // R2: reset mask enables only line 4
        set_lines(16'h0010);
        rd(4'h0, d);
        chk("R2 line4 vector", d, 16'd20);
        chk("R2 line4 irq", {15'h0, irq_o}, 16'h1);
        set_lines(16'h0008);
        rd(4'h0, d);
        chk("R2 masked line3 vector", d, 16'h0);
        chk("R2 masked line3 irq", {15'h0, irq_o}, 16'h0);

        // R4: mask replace and readback
        wr(4'h2, 16'hFFFF);
        rd(4'h2, d);
        chk("R4 mask readback", d, 16'hFFFF);

        // R1/R3: every single line and every suffix pattern
        for (int i = 0; i < 16; i++) begin
            set_lines(16'(1) << i);
            rd(4'h0, d);
            chk("R3 single line vector", d, 16'((i + 1) * 4));
            chk("R1 single line irq", {15'h0, irq_o}, 16'h1);
            set_lines(16'hFFFF << i);
            rd(4'h0, d);
            chk("R3 suffix vector", d, 16'((i + 1) * 4));
        end

        // R1: line dropped clears the source
        set_lines(16'h0);
        rd(4'h0, d);
        chk("R1 lines low vector", d, 16'h0);
        chk("R1 lines low irq", {15'h0, irq_o}, 16'h0);

        // R2: every mask bit with all lines high, then empty mask
        for (int j = 0; j < 16; j++) begin
            set_lines(16'hFFFF);
            wr(4'h2, 16'(1) << j);
            rd(4'h0, d);
            chk("R2 mask bit vector", d, 16'((j + 1) * 4));
            chk("R2 mask bit irq", {15'h0, irq_o}, 16'h1);
        end
        wr(4'h2, 16'h0);
        rd(4'h0, d);
        chk("R2 empty mask vector", d, 16'h0);
        chk("R2 empty mask irq", {15'h0, irq_o}, 16'h0);

        // R2/R3: pseudo-random line and mask pairs
        lf = 16'hACE1;
        for (int n = 0; n < 300; n++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            lines = lf;
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            mask = lf & {lf[7:0], lf[15:8]};
            wr(4'h2, mask);
            set_lines(lines);
            rd(4'h0, d);
            chk("R3 random vector", d, exp_vec(lines & mask));
            chk("R2 random irq", {15'h0, irq_o}, {15'h0, |(lines & mask)});
        end

        // R2: one clock of output latency on rise and fall
        wr(4'h2, 16'hFFFF);
        set_lines(16'h0);
        repeat (3) @(negedge clk);
        irq_lvl_i = 16'h0100;
        @(negedge clk);
        chk("R2 irq not yet raised", {15'h0, irq_o}, 16'h0);
        @(negedge clk);
        chk("R2 irq raised", {15'h0, irq_o}, 16'h1);
        irq_lvl_i = 16'h0;
        @(negedge clk);
        chk("R2 irq not yet dropped", {15'h0, irq_o}, 16'h1);
        @(negedge clk);
        chk("R2 irq dropped", {15'h0, irq_o}, 16'h0);

        // R6: writes off the mask offset are ignored
        wr(4'h2, 16'h1234);
        for (int a = 0; a < 16; a++) begin
            if (a != 2) wr(4'(a), 16'hFFFF);
        end
        rd(4'h2, d);
        chk("R6 mask after stray writes", d, 16'h1234);

        // R7: unmapped reads return zero
        for (int a = 0; a < 16; a++) begin
            if (a != 0 && a != 2) begin
                rd(4'(a), d);
                chk("R7 unmapped read", d, 16'h0);
            end
        end

        // R8/R9: vector reads have no side effect; data holds between reads
        wr(4'h2, 16'h00F0);
        set_lines(16'h00A0);
        rd(4'h0, d);
        rd(4'h0, d2);
        chk("R8 repeat vector", d2, d);
        chk("R8 vector value", d, 16'd24);
        repeat (4) @(negedge clk);
        chk("R9 rdata holds", bus_rdata_o, 16'd24);
        rd(4'h2, d);
        chk("R8 mask unchanged", d, 16'h00F0);
        chk("R8 irq still high", {15'h0, irq_o}, 16'h1);

        // R5: reset mid-run restores mask and clears output
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R5 irq mid reset", {15'h0, irq_o}, 16'h0);
        irq_lvl_i = 16'h0;
        rst_n = 1'b1;
        rd(4'h2, d);
        chk("R5 mask after reset", d, 16'h0010);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule